// File: doc/BRIEF.md
# Watchdog Reset Escalator

This block converts a single watchdog timeout pulse into a chip reset. Software can delay that reset but can never stop it. The path runs through two cascaded holding stages, and each stage is switched on separately.

The first stage runs on the bus clock. When the watchdog interrupt is enabled, a timeout sets a sticky flag and raises a watchdog interrupt. The reset request is then held back for a fixed number of bus cycles, so the interrupt handler has time to run before the request leaves this stage. When the watchdog interrupt is disabled, the request leaves at once.

The request crosses into the slow low-power clock domain through a flop synchronizer, where the second stage acts as the reset controller. If both its group interrupt enable and its watchdog-source enable are set, it raises a reset-controller interrupt. It then counts a selectable number of low-power cycles before it forces the reset. If either enable is clear, it forces the reset as soon as the request arrives.

Configuration is written through a simple bus-clock strobe. Once a timeout has been captured, the configuration is frozen until the next reset. Only the async reset returns the block to idle.

Top module: `wdt_reset_escalator`

## Requirements
- R1: After reset, wdog_flag, wdog_irq, rst_req, rstctl_irq and chip_rst are all 0.
- R2: With the watchdog interrupt enable set, a captured timeout sets wdog_flag and wdog_irq on the capturing bus edge.
- R3: With the watchdog interrupt enable set, rst_req rises exactly 128 bus cycles after the edge that captured the timeout.
- R4: With the watchdog interrupt enable clear, rst_req rises on the capturing edge itself and wdog_flag stays 0.
- R5: Once rst_req is high it stays high until reset, whatever the inputs do.
- R6: A flag_clr pulse clears wdog_flag and wdog_irq without affecting rst_req or the pending reset. A timeout and flag_clr in the same cycle leave the flag set.
- R7: A configuration write is ignored once a timeout has been captured, and in the cycle of the capture itself. Enables and delay select keep their earlier values until reset.
- R8: With both reset-controller enables set, rstctl_irq rises and stays high, and chip_rst follows N low-power cycles later. The 2-bit delay select maps 0, 1, 2, 3 to N = 10, 34, 130, 514.
- R9: With either reset-controller enable clear, chip_rst rises without rstctl_irq. The reset-controller output (chip_rst, or rstctl_irq when the delay is enabled) appears within 4 low-power cycles of rst_req rising.
- R10: The reset-controller delay behaves the same whether or not the watchdog interrupt enable is set.
- R11: Once chip_rst is high it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock, first stage |
| clk_lpo | input | 1 | Low-power oscillator clock, second stage |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wdog_timeout | input | 1 | Watchdog timeout pulse, bus domain |
| flag_clr | input | 1 | Write-1-to-clear strobe for the watchdog flag |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdog_ie | input | 1 | Watchdog interrupt enable value |
| cfg_rstctl_ie | input | 1 | Reset-controller group interrupt enable value |
| cfg_wdsrc_ie | input | 1 | Reset-controller watchdog-source enable value |
| cfg_dly | input | 2 | Reset-controller delay select |
| wdog_flag | output | 1 | Sticky watchdog timeout flag |
| wdog_irq | output | 1 | Watchdog interrupt request |
| rst_req | output | 1 | Reset request leaving the bus stage |
| rstctl_irq | output | 1 | Reset-controller interrupt request |
| chip_rst | output | 1 | Forced chip reset |

## Verification
The bench measures each delay exactly, in edges of its own clock. An off-by-one counter in either stage would therefore show up as a delay of 127, 129, 9 or 11 instead of the required value, and a wrong delay-select decode would pick another row's length. It clears the flag in the middle of the bus hold and rewrites the configuration during the hold, to show that a design which let software abort or retune the escalation would either lose the reset or change its timing. It also sets the flag and clears it in the same cycle, where a wrong priority leaves the flag at 0. Finally, it issues fresh timeouts after the reset has fired, to show that the outputs do not drop back.

// File: rtl/wre_pkg.sv
package wre_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_HOLD,
        BUS_REQ
    } bus_st_e;

    typedef enum logic [1:0] {
        LP_IDLE,
        LP_HOLD,
        LP_RST
    } lp_st_e;

    // low-power hold length for a delay select value: 2^(shift+2*sel) + off
    function automatic int unsigned lp_cycles(input logic [1:0] sel,
                                              input int unsigned shift,
                                              input int unsigned off);
        return (32'd1 << (shift + 2 * int'(sel))) + off;
    endfunction

endpackage

// File: rtl/wre_bus_stage.sv
module wre_bus_stage
    import wre_pkg::*;
#(
    parameter int unsigned BUS_DLY = 128,
    parameter int unsigned DLY_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             timeout,
    input  logic             flag_clr,
    input  logic             cfg_wr,
    input  logic             cfg_wdog_ie,
    input  logic             cfg_rstctl_ie,
    input  logic             cfg_wdsrc_ie,
    input  logic [DLY_W-1:0] cfg_dly,
    output logic             wdog_flag,
    output logic             wdog_irq,
    output logic             rst_req,
    output logic             rstctl_ie,
    output logic             wdsrc_ie,
    output logic [DLY_W-1:0] dly_sel
);

    localparam int unsigned CW = $clog2(BUS_DLY + 1);
    localparam logic [CW-1:0] LAST = CW'(BUS_DLY - 1);

    typedef struct packed {
        bus_st_e          st;
        logic [CW-1:0]    cnt;
        logic             flag;
        logic             ie;
        logic             gie;
        logic             sie;
        logic [DLY_W-1:0] dly;
        logic             req;
    } bus_state_t;

    bus_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // configuration only accepted while idle and not in the capture cycle
        if (s_q.st == BUS_IDLE && cfg_wr && !timeout) begin
            s_d.ie  = cfg_wdog_ie;
            s_d.gie = cfg_rstctl_ie;
            s_d.sie = cfg_wdsrc_ie;
            s_d.dly = cfg_dly;
        end
        if (flag_clr) begin
            s_d.flag = 1'b0;
        end
        unique case (s_q.st)
            BUS_IDLE: begin
                if (timeout) begin
                    s_d.cnt = '0;
                    if (s_q.ie) begin
                        s_d.flag = 1'b1;
                        s_d.st   = BUS_HOLD;
                    end else begin
                        s_d.st  = BUS_REQ;
                        s_d.req = 1'b1;
                    end
                end
            end
            BUS_HOLD: begin
                s_d.cnt = s_q.cnt + CW'(1);
                if (s_q.cnt == LAST) begin
                    s_d.st  = BUS_REQ;
                    s_d.req = 1'b1;
                end
            end
            BUS_REQ: begin
                s_d.req = 1'b1;
            end
            default: s_d.st = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: BUS_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign wdog_flag = s_q.flag;
    assign wdog_irq  = s_q.flag & s_q.ie;
    assign rst_req   = s_q.req;
    assign rstctl_ie = s_q.gie;
    assign wdsrc_ie  = s_q.sie;
    assign dly_sel   = s_q.dly;

    // R5: request never withdrawn
    assert_req_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.req |=> s_q.req);

    // R2: flag only rises with the watchdog interrupt enabled
    assert_flag_needs_ie_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.flag) |-> s_q.ie);

    // R7: configuration frozen once escalation has begun
    assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != BUS_IDLE) |=> $stable({s_q.ie, s_q.gie, s_q.sie, s_q.dly}));

    // R3: with the interrupt enabled the request comes out of the hold phase
    assert_req_after_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(s_q.req) && s_q.ie) |-> ($past(s_q.st) == BUS_HOLD));

    // R4: with the interrupt disabled the request comes straight from idle
    assert_req_direct_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(s_q.req) && !s_q.ie) |-> ($past(s_q.st) == BUS_IDLE));

endmodule

// File: rtl/wre_sync.sv
module wre_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign dout = sr_q[STAGES-1];

endmodule

// File: rtl/wre_lpo_stage.sv
module wre_lpo_stage
    import wre_pkg::*;
#(
    parameter int unsigned LP_SHIFT  = 3,
    parameter int unsigned LP_OFFSET = 2,
    parameter int unsigned DLY_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             rstctl_ie,
    input  logic             wdsrc_ie,
    input  logic [DLY_W-1:0] dly_sel,
    output logic             rstctl_irq,
    output logic             chip_rst
);

    localparam int unsigned LP_MAX = lp_cycles(2'd3, LP_SHIFT, LP_OFFSET);
    localparam int unsigned CW     = $clog2(LP_MAX + 1);

    typedef struct packed {
        lp_st_e        st;
        logic [CW-1:0] cnt;
        logic          irq;
        logic          rst;
    } lp_state_t;

    lp_state_t s_d, s_q;
    logic [CW-1:0] last_cnt;
    logic          irq_path;

    assign irq_path = rstctl_ie & wdsrc_ie;
    assign last_cnt = CW'(lp_cycles(2'(dly_sel), LP_SHIFT, LP_OFFSET) - 1);

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            LP_IDLE: begin
                if (req) begin
                    s_d.cnt = '0;
                    if (irq_path) begin
                        s_d.irq = 1'b1;
                        s_d.st  = LP_HOLD;
                    end else begin
                        s_d.rst = 1'b1;
                        s_d.st  = LP_RST;
                    end
                end
            end
            LP_HOLD: begin
                s_d.cnt = s_q.cnt + CW'(1);
                if (s_q.cnt == last_cnt) begin
                    s_d.rst = 1'b1;
                    s_d.st  = LP_RST;
                end
            end
            LP_RST: begin
                s_d.rst = 1'b1;
            end
            default: s_d.st = LP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: LP_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign rstctl_irq = s_q.irq;
    assign chip_rst   = s_q.rst;

    // R11: forced reset is never released
    assert_rst_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rst |=> s_q.rst);

    // R8: interrupt stays raised once set
    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.irq |=> s_q.irq);

    // R8: with the interrupt path on, the interrupt precedes the reset
    assert_irq_before_rst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(s_q.rst) && irq_path) |-> (s_q.irq && $past(s_q.st) == LP_HOLD));

    // R9: no reset without a synchronized request
    assert_rst_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rst |-> req);

endmodule

// File: rtl/wdt_reset_escalator.sv
module wdt_reset_escalator
    import wre_pkg::*;
#(
    parameter int unsigned BUS_DLY     = 128,
    parameter int unsigned LP_SHIFT    = 3,
    parameter int unsigned LP_OFFSET   = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk_bus,
    input  logic       clk_lpo,
    input  logic       rst_n,
    input  logic       wdog_timeout,
    input  logic       flag_clr,
    input  logic       cfg_wr,
    input  logic       cfg_wdog_ie,
    input  logic       cfg_rstctl_ie,
    input  logic       cfg_wdsrc_ie,
    input  logic [1:0] cfg_dly,
    output logic       wdog_flag,
    output logic       wdog_irq,
    output logic       rst_req,
    output logic       rstctl_irq,
    output logic       chip_rst
);

    localparam int unsigned DLY_W = 2;

    logic             gie_q;
    logic             sie_q;
    logic [DLY_W-1:0] dly_q;
    logic             req_lp;

    wre_bus_stage #(
        .BUS_DLY (BUS_DLY),
        .DLY_W   (DLY_W)
    ) u_bus (
        .clk           (clk_bus),
        .rst_n         (rst_n),
        .timeout       (wdog_timeout),
        .flag_clr      (flag_clr),
        .cfg_wr        (cfg_wr),
        .cfg_wdog_ie   (cfg_wdog_ie),
        .cfg_rstctl_ie (cfg_rstctl_ie),
        .cfg_wdsrc_ie  (cfg_wdsrc_ie),
        .cfg_dly       (cfg_dly),
        .wdog_flag     (wdog_flag),
        .wdog_irq      (wdog_irq),
        .rst_req       (rst_req),
        .rstctl_ie     (gie_q),
        .wdsrc_ie      (sie_q),
        .dly_sel       (dly_q)
    );

    wre_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk_lpo),
        .rst_n (rst_n),
        .din   (rst_req),
        .dout  (req_lp)
    );

    wre_lpo_stage #(
        .LP_SHIFT  (LP_SHIFT),
        .LP_OFFSET (LP_OFFSET),
        .DLY_W     (DLY_W)
    ) u_lpo (
        .clk        (clk_lpo),
        .rst_n      (rst_n),
        .req        (req_lp),
        .rstctl_ie  (gie_q),
        .wdsrc_ie   (sie_q),
        .dly_sel    (dly_q),
        .rstctl_irq (rstctl_irq),
        .chip_rst   (chip_rst)
    );

endmodule

// File: tb/tb_wdt_reset_escalator.sv
module tb_wdt_reset_escalator;

    logic       clk_bus = 1'b0;
    logic       clk_lpo = 1'b0;
    logic       rst_n = 1'b0;
    logic       wdog_timeout = 1'b0;
    logic       flag_clr = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_wdog_ie = 1'b0;
    logic       cfg_rstctl_ie = 1'b0;
    logic       cfg_wdsrc_ie = 1'b0;
    logic [1:0] cfg_dly = 2'd0;
    logic       wdog_flag, wdog_irq, rst_req, rstctl_irq, chip_rst;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk_bus = ~clk_bus;   // 250 MHz
    always #16 clk_lpo = ~clk_lpo;  // slow low-power clock

    wdt_reset_escalator dut (
        .clk_bus       (clk_bus),
        .clk_lpo       (clk_lpo),
        .rst_n         (rst_n),
        .wdog_timeout  (wdog_timeout),
        .flag_clr      (flag_clr),
        .cfg_wr        (cfg_wr),
        .cfg_wdog_ie   (cfg_wdog_ie),
        .cfg_rstctl_ie (cfg_rstctl_ie),
        .cfg_wdsrc_ie  (cfg_wdsrc_ie),
        .cfg_dly       (cfg_dly),
        .wdog_flag     (wdog_flag),
        .wdog_irq      (wdog_irq),
        .rst_req       (rst_req),
        .rstctl_irq    (rstctl_irq),
        .chip_rst      (chip_rst)
    );

    // {wdog_ie, rstctl_ie, wdsrc_ie, dly[1:0], bus_delay[8:0], lpo_delay[9:0]}; lpo_delay 0 = no interrupt path
    localparam logic [23:0] VEC [8] = '{
        {1'b1, 1'b1, 1'b1, 2'd0, 9'd128, 10'd10},
        {1'b1, 1'b1, 1'b1, 2'd1, 9'd128, 10'd34},
        {1'b1, 1'b1, 1'b1, 2'd2, 9'd128, 10'd130},
        {1'b1, 1'b1, 1'b1, 2'd3, 9'd128, 10'd514},
        {1'b0, 1'b1, 1'b1, 2'd0, 9'd0,   10'd10},
        {1'b1, 1'b0, 1'b1, 2'd3, 9'd128, 10'd0},
        {1'b1, 1'b1, 1'b0, 2'd1, 9'd128, 10'd0},
        {1'b0, 1'b0, 1'b0, 2'd2, 9'd0,   10'd0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk_bus);
        rst_n = 1'b0;
        wdog_timeout = 1'b0;
        flag_clr = 1'b0;
        cfg_wr = 1'b0;
        repeat (2) @(negedge clk_lpo);
        @(negedge clk_bus);
        rst_n = 1'b1;
    endtask

    // callers are at a bus negedge
    task automatic cfg_write(input bit ie, input bit gie, input bit sie, input logic [1:0] d);
        cfg_wr = 1'b1;
        cfg_wdog_ie = ie;
        cfg_rstctl_ie = gie;
        cfg_wdsrc_ie = sie;
        cfg_dly = d;
        @(posedge clk_bus);
        @(negedge clk_bus);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse_timeout(input bit with_clr);
        wdog_timeout = 1'b1;
        flag_clr = with_clr;
        @(posedge clk_bus);
        @(negedge clk_bus);
        wdog_timeout = 1'b0;
        flag_clr = 1'b0;
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1;
        @(posedge clk_bus);
        @(negedge clk_bus);
        flag_clr = 1'b0;
    endtask

    // count bus cycles until rst_req, starting from the given count
    task automatic wait_req(inout int n);
        while (!rst_req && n < 400) begin
            @(posedge clk_bus);
            @(negedge clk_bus);
            n++;
        end
    endtask

    // wait for the reset-controller to react; returns low-power cycles taken
    task automatic wait_lpo_react(output int m);
        m = 0;
        while (!(rstctl_irq || chip_rst) && m < 50) begin
            @(negedge clk_lpo);
            m++;
        end
    endtask

    task automatic count_lpo_hold(output int n);
        n = 0;
        while (!chip_rst && n < 700) begin
            @(posedge clk_lpo);
            @(negedge clk_lpo);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk_bus);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", 150000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        int m;
        // R1: reset state
        do_reset();
        chk({wdog_flag, wdog_irq, rst_req, rstctl_irq, chip_rst} == 5'b0, "R1 reset state",
            int'({wdog_flag, wdog_irq, rst_req, rstctl_irq, chip_rst}), 0);

        foreach (VEC[i]) begin
            logic [23:0] v;
            v = VEC[i];
            do_reset();
            @(negedge clk_bus);
            cfg_write(v[23], v[22], v[21], v[20:19]);
            pulse_timeout(1'b0);
            if (v[23]) begin
                chk(wdog_flag == 1'b1, "R2 flag set", int'(wdog_flag), 1);
                chk(wdog_irq == 1'b1, "R2 irq raised", int'(wdog_irq), 1);
            end else begin
                chk(wdog_flag == 1'b0, "R4 flag stays clear", int'(wdog_flag), 0);
            end
            n = 0;
            wait_req(n);
            chk(n == int'(v[18:10]), v[23] ? "R3 bus hold length" : "R4 no bus hold", n, int'(v[18:10]));
            wait_lpo_react(m);
            chk(m <= 4, "R9 reset-controller reaction latency", m, 4);
            if (v[9:0] != 10'd0) begin
                chk(rstctl_irq && !chip_rst, "R8 interrupt before reset",
                    int'({rstctl_irq, chip_rst}), 2);
                count_lpo_hold(n);
                chk(n == int'(v[9:0]), v[23] ? "R8 low-power hold length" : "R10 hold without wdog irq",
                    n, int'(v[9:0]));
            end else begin
                chk(chip_rst && !rstctl_irq, "R9 direct reset without interrupt",
                    int'({rstctl_irq, chip_rst}), 1);
            end
            repeat (5) @(negedge clk_lpo);
            chk(chip_rst && rst_req, "R11 R5 outputs held", int'({rst_req, chip_rst}), 3);
        end

        // R6: clear during the hold does not cancel the reset
        do_reset();
        @(negedge clk_bus);
        cfg_write(1'b1, 1'b1, 1'b1, 2'd0);
        pulse_timeout(1'b0);
        n = 0;
        repeat (10) begin
            @(posedge clk_bus);
            @(negedge clk_bus);
            n++;
        end
        pulse_clr();
        n++;
        chk(!wdog_flag && !wdog_irq, "R6 flag cleared", int'({wdog_flag, wdog_irq}), 0);
        wait_req(n);
        chk(n == 128, "R6 reset request still issued", n, 128);
        chk(wdog_flag == 1'b0, "R6 flag stays cleared", int'(wdog_flag), 0);

        // R6: timeout and clear in the same cycle leaves the flag set
        do_reset();
        @(negedge clk_bus);
        cfg_write(1'b1, 1'b0, 1'b0, 2'd0);
        pulse_timeout(1'b1);
        chk(wdog_flag == 1'b1, "R6 set wins over clear", int'(wdog_flag), 1);

        // R7: configuration writes during the hold are ignored
        do_reset();
        @(negedge clk_bus);
        cfg_write(1'b1, 1'b1, 1'b1, 2'd1);
        pulse_timeout(1'b0);
        n = 0;
        repeat (5) begin
            @(posedge clk_bus);
            @(negedge clk_bus);
            n++;
        end
        cfg_write(1'b0, 1'b0, 1'b0, 2'd3);
        n++;
        chk(wdog_irq == 1'b1, "R7 watchdog enable frozen", int'(wdog_irq), 1);
        wait_req(n);
        chk(n == 128, "R7 hold unchanged by write", n, 128);
        wait_lpo_react(m);
        chk(rstctl_irq == 1'b1, "R7 reset-controller enables frozen", int'(rstctl_irq), 1);
        count_lpo_hold(n);
        chk(n == 34, "R7 delay select frozen", n, 34);

        // R5 R11: further stimulus after the reset fired changes nothing
        pulse_timeout(1'b1);
        pulse_clr();
        repeat (3) @(negedge clk_lpo);
        chk(rst_req && chip_rst && rstctl_irq, "R11 R5 sticky after new stimulus",
            int'({rst_req, chip_rst, rstctl_irq}), 7);

        // R1: reset clears everything after a completed escalation
        do_reset();
        @(negedge clk_bus);
        chk({wdog_flag, wdog_irq, rst_req, rstctl_irq, chip_rst} == 5'b0, "R1 cleared by reset",
            int'({wdog_flag, wdog_irq, rst_req, rstctl_irq, chip_rst}), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule